// File: doc/BRIEF.md
# Single-Transfer Processor Bus Master

This block is the processor-side engine for one non-burst read or write on a 64-bit data bus. A core-side port hands it an 8-byte-group address, byte enables, direction, memory/I-O and data/code selects, and the page cache-disable, page write-through and cache-intent bits. The block registers these onto the bus and pulses a one-clock address strobe. It then waits for system logic to signal ready. On a read it captures the data and returns it on a one-clock done pulse. With that pulse come the final cacheable and writeback verdicts, which depend on whether the processor's intent and the system replies agree.

The block also checks even data parity on enabled byte lanes. A mismatch raises a one-clock parity-check output two clocks after the ready that carried the data. At least one idle clock always separates two bus cycles. All control pins are active high. `bus_mem` = 1 means a memory cycle, `bus_data_cyc` = 1 means a data cycle (0 = code fetch), and `bus_wr` = 1 means a write.

The sequencer has four states:
- ST_IDLE goes to ST_STROBE when a request is accepted.
- ST_STROBE always goes to ST_WAIT.
- ST_WAIT stays in ST_WAIT until ready, then goes to ST_GAP.
- ST_GAP goes to ST_STROBE if a new request is accepted, otherwise to ST_IDLE.

Top module: `sbus_master`

## Requirements
- R1: In the clock where `bus_ads` is high, `bus_addr`, `bus_wr`, `bus_mem` (= !req_io), `bus_data_cyc` (= !req_code), `bus_pcd`, `bus_pwt` and `bus_cache` equal the accepted request. For a write, `bus_dout` equals the write data and `bus_dpo[i]` is the even parity of byte lane i (`bits [8i+7:8i]`).
- R2: A code-fetch read whose intent is non-cacheable (`req_cache` low or `req_pcd` high) drives `bus_be` = 8'hFF. Any other request drives `req_be` unchanged.
- R3: `bus_ads` is high for exactly one clock, in the clock after the request is accepted. `bus_req` is high from that clock through the clock in which ready is sampled.
- R4: `bus_ap` is even parity over `bus_addr`, so the XOR of `bus_addr` and `bus_ap` is 0.
- R5: Ready is honoured from the first clock after the strobe. In the next clock, `done` pulses for one clock with `done_rdata` equal to the read data sampled with ready.
- R6: `req_ready` is low from the strobe clock through the ready clock, and requests made meanwhile are ignored. The earliest next strobe comes two clocks after ready, leaving one idle clock.
- R7: `done_cacheable` is 1 only for a read where `bus_cache` is 1, `bus_pcd` is 0 and `bus_ken` is 1 when ready is sampled. It is 0 for writes.
- R8: `done_writeback` is 1 only when the access is cacheable, `bus_pwt` is 0 and `bus_wb` is 1 (1 selects writeback) when ready is sampled.
- R9: On a read, if for some lane i with an active byte enable the XOR of `bus_din[8i+7:8i]` and `bus_dpi[i]` is 1, `bus_pchk` pulses for one clock two clocks after ready. Mismatches on disabled lanes and on writes are ignored.
- R10: Synchronous active-high `rst` returns the block to ST_IDLE. After reset, `bus_ads`, `bus_req`, `bus_pchk` and `done` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Block can accept a request this clock |
| req_addr | input | 29 | Address bits above the 8-byte group |
| req_be | input | 8 | Requested byte enables |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O cycle, 0 = memory |
| req_code | input | 1 | 1 = code fetch, 0 = data |
| req_pcd | input | 1 | Page cache-disable bit |
| req_pwt | input | 1 | Page write-through bit |
| req_cache | input | 1 | Core cache intent |
| req_wdata | input | 64 | Write data |
| bus_addr | output | 29 | Bus address |
| bus_be | output | 8 | Bus byte enables |
| bus_ap | output | 1 | Even address parity |
| bus_wr | output | 1 | 1 = write cycle |
| bus_mem | output | 1 | 1 = memory cycle |
| bus_data_cyc | output | 1 | 1 = data cycle, 0 = code |
| bus_pcd | output | 1 | Cache-disable to system |
| bus_pwt | output | 1 | Write-through to system |
| bus_cache | output | 1 | Cache intent to system |
| bus_ads | output | 1 | One-clock address strobe |
| bus_req | output | 1 | Cycle outstanding |
| bus_dout | output | 64 | Write data to bus |
| bus_doe | output | 1 | Write data drive enable |
| bus_dpo | output | 8 | Write data lane parity |
| bus_din | input | 64 | Read data from bus |
| bus_dpi | input | 8 | Read data lane parity |
| bus_rdy | input | 1 | Ready from system logic |
| bus_ken | input | 1 | System cache enable |
| bus_wb | input | 1 | 1 = writeback, 0 = write-through |
| done | output | 1 | One-clock completion pulse |
| done_rdata | output | 64 | Read data |
| done_cacheable | output | 1 | Final cacheable verdict |
| done_writeback | output | 1 | Final writeback verdict |
| bus_pchk | output | 1 | One-clock data parity error |

## Verification
The assertions watch the timing skeleton on every clock. They check that the strobe is a single clock and that address parity is right while it is high. They check that `bus_req` and `req_ready` never overlap, that a taken ready is followed by `done` and an idle clock, that the parity-check pulse follows `done` by one clock, and that the cacheable and writeback verdicts never contradict the pins they come from. Only the bench scenarios show data-dependent results. These include the captured read value, the code-fetch byte-enable override, parity errors on enabled versus disabled lanes, requests ignored while busy, the exact two-clock restart after ready, and recovery from a reset in mid-cycle.

// File: rtl/sbus_pkg.sv
`timescale 1ns/1ps
package sbus_pkg;
    localparam int LANE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_STROBE,
        ST_WAIT,
        ST_GAP
    } bus_state_e;
endpackage

// File: rtl/sbus_even_par.sv
`timescale 1ns/1ps
// Even parity bit over a vector: vec together with par has an even number of ones.
module sbus_even_par #(
    parameter int W = 8
) (
    input  logic [W-1:0] vec,
    output logic         par
);
    assign par = ^vec;
endmodule

// File: rtl/sbus_lane_check.sv
`timescale 1ns/1ps
// Per-lane even parity checker, masked by lane enables.
module sbus_lane_check #(
    parameter int LANES  = 8,
    parameter int LANE_W = 8
) (
    input  logic [LANES*LANE_W-1:0] data,
    input  logic [LANES-1:0]        par,
    input  logic [LANES-1:0]        en,
    output logic                    mismatch
);
    logic [LANES-1:0] calc;
    logic [LANES-1:0] lane_err;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        sbus_even_par #(.W(LANE_W)) u_par (
            .vec (data[i*LANE_W +: LANE_W]),
            .par (calc[i])
        );
        assign lane_err[i] = en[i] & (calc[i] ^ par[i]);
    end

    assign mismatch = |lane_err;
endmodule

// File: rtl/sbus_cache_decide.sv
`timescale 1ns/1ps
// Final caching verdict from processor intent and system replies.
module sbus_cache_decide (
    input  logic intent,
    input  logic pcd,
    input  logic pwt,
    input  logic ken,
    input  logic wb_sel,
    output logic cacheable,
    output logic writeback
);
    always_comb begin
        cacheable = intent && !pcd && ken;
        writeback = cacheable && !pwt && wb_sel;
    end
endmodule

// File: rtl/sbus_master.sv
`timescale 1ns/1ps
module sbus_master #(
    parameter  int ADDR_W = 32,
    parameter  int DATA_W = 64,
    localparam int LANES  = DATA_W / sbus_pkg::LANE_W,
    localparam int LSB    = $clog2(LANES),
    localparam int AW     = ADDR_W - LSB
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [AW-1:0]     req_addr,
    input  logic [LANES-1:0]  req_be,
    input  logic              req_write,
    input  logic              req_io,
    input  logic              req_code,
    input  logic              req_pcd,
    input  logic              req_pwt,
    input  logic              req_cache,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [AW-1:0]     bus_addr,
    output logic [LANES-1:0]  bus_be,
    output logic              bus_ap,
    output logic              bus_wr,
    output logic              bus_mem,
    output logic              bus_data_cyc,
    output logic              bus_pcd,
    output logic              bus_pwt,
    output logic              bus_cache,
    output logic              bus_ads,
    output logic              bus_req,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_doe,
    output logic [LANES-1:0]  bus_dpo,
    input  logic [DATA_W-1:0] bus_din,
    input  logic [LANES-1:0]  bus_dpi,
    input  logic              bus_rdy,
    input  logic              bus_ken,
    input  logic              bus_wb,
    output logic              done,
    output logic [DATA_W-1:0] done_rdata,
    output logic              done_cacheable,
    output logic              done_writeback,
    output logic              bus_pchk
);
    import sbus_pkg::*;

    bus_state_e state_q, state_d;

    logic              accept;
    logic              rdy_hit;
    logic              launch;
    logic              live;
    logic              req_noncache;
    logic [LANES-1:0]  be_eff;
    logic              ap_d;
    logic [LANES-1:0]  wpar_d;
    logic              cd_cache;
    logic              cd_wb;
    logic [DATA_W-1:0] cap_din;
    logic [LANES-1:0]  cap_dpi;
    logic [LANES-1:0]  cap_be;
    logic              cap_chk;
    logic              mism;

    // Handshake and request shaping
    assign req_ready    = (state_q == ST_IDLE) || (state_q == ST_GAP);
    assign accept       = req_valid && req_ready;
    assign rdy_hit      = (state_q == ST_WAIT) && bus_rdy;
    assign req_noncache = !(req_cache && !req_pcd);
    assign be_eff       = (req_code && !req_write && req_noncache) ? '1 : req_be;

    sbus_even_par #(.W(AW)) u_addr_par (
        .vec (req_addr),
        .par (ap_d)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_wpar
        sbus_even_par #(.W(LANE_W)) u_wpar (
            .vec (req_wdata[i*LANE_W +: LANE_W]),
            .par (wpar_d[i])
        );
    end

    sbus_cache_decide u_decide (
        .intent    (bus_cache),
        .pcd       (bus_pcd),
        .pwt       (bus_pwt),
        .ken       (bus_ken),
        .wb_sel    (bus_wb),
        .cacheable (cd_cache),
        .writeback (cd_wb)
    );

    sbus_lane_check #(.LANES(LANES), .LANE_W(LANE_W)) u_dchk (
        .data     (cap_din),
        .par      (cap_dpi),
        .en       (cap_be),
        .mismatch (mism)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = ST_STROBE;
            ST_STROBE: state_d = ST_WAIT;
            ST_WAIT:   if (rdy_hit) state_d = ST_GAP;
            ST_GAP:    state_d = accept ? ST_STROBE : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    assign launch = (state_d == ST_STROBE);
    assign live   = (state_d == ST_STROBE) || (state_d == ST_WAIT);

    // Registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            bus_addr       <= '0;
            bus_be         <= '0;
            bus_ap         <= 1'b0;
            bus_wr         <= 1'b0;
            bus_mem        <= 1'b0;
            bus_data_cyc   <= 1'b0;
            bus_pcd        <= 1'b0;
            bus_pwt        <= 1'b0;
            bus_cache      <= 1'b0;
            bus_ads        <= 1'b0;
            bus_req        <= 1'b0;
            bus_dout       <= '0;
            bus_doe        <= 1'b0;
            bus_dpo        <= '0;
            done           <= 1'b0;
            done_rdata     <= '0;
            done_cacheable <= 1'b0;
            done_writeback <= 1'b0;
            cap_din        <= '0;
            cap_dpi        <= '0;
            cap_be         <= '0;
            cap_chk        <= 1'b0;
            bus_pchk       <= 1'b0;
        end else begin
            bus_ads <= launch;
            bus_req <= live;
            if (accept) begin
                bus_addr     <= req_addr;
                bus_be       <= be_eff;
                bus_ap       <= ap_d;
                bus_wr       <= req_write;
                bus_mem      <= !req_io;
                bus_data_cyc <= !req_code;
                bus_pcd      <= req_pcd;
                bus_pwt      <= req_pwt;
                bus_cache    <= req_cache;
                bus_dout     <= req_write ? req_wdata : '0;
                bus_dpo      <= req_write ? wpar_d : '0;
            end
            bus_doe <= live && (accept ? req_write : bus_wr);
            done    <= rdy_hit;
            if (rdy_hit) begin
                done_rdata     <= bus_wr ? '0 : bus_din;
                done_cacheable <= !bus_wr && cd_cache;
                done_writeback <= !bus_wr && cd_wb;
                cap_din        <= bus_din;
                cap_dpi        <= bus_dpi;
                cap_be         <= bus_be;
            end
            cap_chk  <= rdy_hit && !bus_wr;
            bus_pchk <= cap_chk && mism;
        end
    end
endmodule

// File: rtl/sbus_master_chk.sv
`timescale 1ns/1ps
module sbus_master_chk #(
    parameter int AW    = 29,
    parameter int LANES = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             req_ready,
    input logic [AW-1:0]    bus_addr,
    input logic [LANES-1:0] bus_be,
    input logic             bus_ap,
    input logic             bus_wr,
    input logic             bus_data_cyc,
    input logic             bus_pcd,
    input logic             bus_pwt,
    input logic             bus_cache,
    input logic             bus_ads,
    input logic             bus_req,
    input logic             bus_rdy,
    input logic             bus_ken,
    input logic             bus_wb,
    input logic             done,
    input logic             done_cacheable,
    input logic             done_writeback,
    input logic             bus_pchk
);
    logic rdy_take;
    assign rdy_take = bus_req && !bus_ads && bus_rdy;

    p_code_be_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_ads && !bus_data_cyc && !bus_wr && !(bus_cache && !bus_pcd)) |-> (bus_be == '1));

    p_strobe_once_r3: assert property (@(posedge clk) disable iff (rst)
        bus_ads |=> !bus_ads);

    p_strobe_req_r3: assert property (@(posedge clk) disable iff (rst)
        bus_ads |-> bus_req);

    p_addr_par_r4: assert property (@(posedge clk) disable iff (rst)
        bus_ads |-> (bus_ap == ^bus_addr));

    p_done_after_rdy_r5: assert property (@(posedge clk) disable iff (rst)
        rdy_take |=> done);

    p_done_src_r5: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(rdy_take));

    p_busy_r6: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> !req_ready);

    p_idle_clock_r6: assert property (@(posedge clk) disable iff (rst)
        rdy_take |=> (!bus_ads && !bus_req));

    p_cacheable_r7: assert property (@(posedge clk) disable iff (rst)
        (done && done_cacheable) |-> (bus_cache && !bus_pcd && !bus_wr && $past(bus_ken)));

    p_writeback_r8: assert property (@(posedge clk) disable iff (rst)
        (done && done_writeback) |-> (done_cacheable && !bus_pwt && $past(bus_wb)));

    p_pchk_delay_r9: assert property (@(posedge clk) disable iff (rst)
        bus_pchk |-> ($past(done) && !bus_wr));

    p_pchk_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        bus_pchk |=> !bus_pchk);

    p_reset_r10: assert property (@(posedge clk)
        rst |=> (!bus_ads && !bus_req && !bus_pchk && !done && req_ready));
endmodule

bind sbus_master sbus_master_chk #(.AW(AW), .LANES(LANES)) u_chk (.*);

// File: tb/tb_sbus_master.sv
`timescale 1ns/1ps
module tb_sbus_master;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_ready;
    logic [28:0] req_addr;
    logic [7:0]  req_be;
    logic        req_write, req_io, req_code, req_pcd, req_pwt, req_cache;
    logic [63:0] req_wdata;
    logic [28:0] bus_addr;
    logic [7:0]  bus_be;
    logic        bus_ap, bus_wr, bus_mem, bus_data_cyc, bus_pcd, bus_pwt, bus_cache;
    logic        bus_ads, bus_req;
    logic [63:0] bus_dout;
    logic        bus_doe;
    logic [7:0]  bus_dpo;
    logic [63:0] bus_din;
    logic [7:0]  bus_dpi;
    logic        bus_rdy, bus_ken, bus_wb;
    logic        done;
    logic [63:0] done_rdata;
    logic        done_cacheable, done_writeback, bus_pchk;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    sbus_master dut (.*);

    typedef struct packed {
        logic [28:0] addr;
        logic [7:0]  be;
        logic        wr;
        logic        io;
        logic        code;
        logic        pcd;
        logic        pwt;
        logic        cache;
        logic [3:0]  dly;
        logic        ken;
        logic        wb;
        logic [63:0] data;
        logic [7:0]  flip;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{29'h0123456, 8'h0F, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd0, 1'b1, 1'b1, 64'h1122334455667788, 8'h00},
        '{29'h1ABCDEF, 8'hF0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'd1, 1'b1, 1'b1, 64'hDEADBEEF00C0FFEE, 8'h10},
        '{29'h0000001, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd0, 1'b1, 1'b1, 64'h0102030405060708, 8'h02},
        '{29'h1000000, 8'h0F, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd2, 1'b1, 1'b1, 64'hA5A5A5A55A5A5A5A, 8'h80},
        '{29'h0F0F0F0, 8'h03, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'd3, 1'b0, 1'b1, 64'h0F1E2D3C4B5A6978, 8'h00},
        '{29'h1555555, 8'hFF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd1, 1'b1, 1'b1, 64'hCAFEF00D12345678, 8'h00},
        '{29'h00000FF, 8'h03, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd2, 1'b0, 1'b0, 64'h00000000000BEEF1, 8'h01},
        '{29'h0AAAAAA, 8'h3C, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd5, 1'b1, 1'b0, 64'h8877665544332211, 8'h00}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] lanepar(input logic [63:0] d);
        logic [7:0] p;
        for (int i = 0; i < 8; i++) p[i] = ^d[8*i +: 8];
        return p;
    endfunction

    task automatic drive_req(input vec_t v);
        req_addr  = v.addr;
        req_be    = v.be;
        req_write = v.wr;
        req_io    = v.io;
        req_code  = v.code;
        req_pcd   = v.pcd;
        req_pwt   = v.pwt;
        req_cache = v.cache;
        req_wdata = v.data;
        req_valid = 1'b1;
    endtask

    task automatic run_txn(input vec_t v);
        logic [7:0] ebe;
        logic       cach, wbx, perr;
        ebe  = (v.code && !v.wr && !(v.cache && !v.pcd)) ? 8'hFF : v.be;
        cach = !v.wr && v.cache && !v.pcd && v.ken;
        wbx  = cach && !v.pwt && v.wb;
        perr = !v.wr && (|(v.flip & ebe));
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        drive_req(v);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R3 strobe high", 64'(bus_ads), 64'd1);
        chk("R1 address", 64'(bus_addr), 64'(v.addr));
        chk("R2 byte enables", 64'(bus_be), 64'(ebe));
        chk("R4 address parity", 64'(bus_ap), 64'(^v.addr));
        chk("R1 cycle definition",
            64'({bus_wr, bus_mem, bus_data_cyc, bus_pcd, bus_pwt, bus_cache}),
            64'({v.wr, !v.io, !v.code, v.pcd, v.pwt, v.cache}));
        chk("R6 busy at strobe", 64'(req_ready), 64'd0);
        if (v.wr) begin
            chk("R1 write data", bus_dout, v.data);
            chk("R1 write lane parity", 64'(bus_dpo), 64'(lanepar(v.data)));
            chk("R1 write drive", 64'(bus_doe), 64'd1);
        end
        for (int k = 0; k < int'(v.dly); k++) begin
            @(negedge clk);
            chk("R3 single-clock strobe", 64'(bus_ads), 64'd0);
            chk("R3 request held", 64'(bus_req), 64'd1);
        end
        @(negedge clk);
        chk("R3 strobe low in wait", 64'(bus_ads), 64'd0);
        bus_rdy = 1'b1;
        bus_din = v.data;
        bus_dpi = lanepar(v.data) ^ v.flip;
        bus_ken = v.ken;
        bus_wb  = v.wb;
        @(negedge clk);
        bus_rdy = 1'b0;
        bus_ken = 1'b0;
        bus_wb  = 1'b0;
        chk("R5 done pulse", 64'(done), 64'd1);
        if (!v.wr) chk("R5 read data", done_rdata, v.data);
        chk("R7 cacheable", 64'(done_cacheable), 64'(cach));
        chk("R8 writeback", 64'(done_writeback), 64'(wbx));
        chk("R6 idle clock", 64'({bus_ads, bus_req}), 64'd0);
        chk("R6 ready after cycle", 64'(req_ready), 64'd1);
        chk("R9 no early pchk", 64'(bus_pchk), 64'd0);
        @(negedge clk);
        chk("R9 parity check", 64'(bus_pchk), 64'(perr));
        chk("R5 done single clock", 64'(done), 64'd0);
        @(negedge clk);
        chk("R9 pchk single clock", 64'(bus_pchk), 64'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog R5 act=hung exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        vec_t g;
        rst = 1'b1;
        req_valid = 1'b0;
        req_addr = '0; req_be = '0; req_write = 1'b0; req_io = 1'b0; req_code = 1'b0;
        req_pcd = 1'b0; req_pwt = 1'b0; req_cache = 1'b0; req_wdata = '0;
        bus_din = '0; bus_dpi = '0; bus_rdy = 1'b0; bus_ken = 1'b0; bus_wb = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 reset outputs", 64'({bus_ads, bus_req, bus_pchk, done}), 64'd0);
        chk("R10 reset ready", 64'(req_ready), 64'd1);
        rst = 1'b0;

        // Vector table
        for (int n = 0; n < NV; n++) run_txn(VECS[n]);

        // Directed: requests ignored while busy, then restart two clocks after ready
        g = VECS[0];
        @(negedge clk);
        drive_req(g);
        @(negedge clk);
        chk("R3 strobe directed", 64'(bus_ads), 64'd1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R6 no strobe while busy", 64'(bus_ads), 64'd0);
            chk("R6 not ready while busy", 64'(req_ready), 64'd0);
        end
        bus_rdy = 1'b1;
        bus_din = 64'h0BADF00D0BADF00D;
        bus_dpi = lanepar(64'h0BADF00D0BADF00D);
        req_addr = 29'h1234567;
        @(negedge clk);
        bus_rdy = 1'b0;
        chk("R5 done directed", 64'(done), 64'd1);
        chk("R5 read data directed", done_rdata, 64'h0BADF00D0BADF00D);
        chk("R6 idle clock after ready", 64'(bus_ads), 64'd0);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R6 strobe two clocks after ready", 64'(bus_ads), 64'd1);
        chk("R1 second address", 64'(bus_addr), 64'h1234567);
        @(negedge clk);
        bus_rdy = 1'b1;
        bus_dpi = lanepar(bus_din);
        @(negedge clk);
        bus_rdy = 1'b0;
        chk("R5 second done", 64'(done), 64'd1);

        // Directed: reset in the middle of a cycle
        @(negedge clk);
        @(negedge clk);
        drive_req(VECS[2]);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R3 strobe before reset", 64'(bus_ads), 64'd1);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R10 mid-cycle reset outputs", 64'({bus_ads, bus_req, bus_pchk, done}), 64'd0);
        chk("R10 mid-cycle reset ready", 64'(req_ready), 64'd1);
        bus_rdy = 1'b1;
        @(negedge clk);
        bus_rdy = 1'b0;
        chk("R10 stray ready ignored", 64'(done), 64'd0);
        run_txn(VECS[7]);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule